// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Block

This block holds the configuration and status registers of a four-bank SDRAM controller. Software reaches them indirectly. A write to the index port selects an internal register. A read or write on the data port then acts on the register that the index selects. Every other bus port reads as zero. Each internal register applies its own write rule, such as a plain store, a field mask, fixed bits that are always set, or write-one-to-clear. A write is ignored when the register is read-only.

When the global enable bit and the self-refresh bit of the configuration register change, the status register follows those changes. The ECC status register drives an interrupt line that is high while the register holds any nonzero bit.

The block also decodes a system address against the four bank registers. Each bank register carries a base address, a size code and a valid bit. The block reports every bank that matches the address and a one-hot select for the lowest-numbered bank that matches. The memory interface, refresh engine and ECC datapath sit outside this block.

Top module: `sdram_cfg_regs`

## Requirements
- R1: Bus port 0x10 reads back the 32-bit index register, and a write there replaces it. Bus port 0x11 reads and writes the internal register that the index selects. Any other bus port reads zero, and a write to any other port changes no state.
- R2: After reset the registers hold these values: power-management idle timer 0x07C00000, refresh timer 0x05F00000, configuration 0x00800000. The index and every other register hold zero.
- R3: The internal offsets are error status A 0x00, error status B 0x08, error address 0x10, configuration 0x20, status 0x24, refresh timer 0x30, idle timer 0x34, banks 0 to 3 at 0x40/0x44/0x48/0x4C, timing 0x80, ECC configuration 0x94 and ECC status 0x98. A read of the timing offset returns 0xFFFFFFFF. A read of any offset not listed here also returns 0xFFFFFFFF. A write to the status offset is ignored.
- R4: A write to either error status register clears the bits written as 1. A write to the error address register stores the full 32-bit value.
- R5: A configuration write stores the value ANDed with 0xFFE00000. If this makes bit 31 go from 0 to 1, status bit 31 is cleared. If it makes bit 31 go from 1 to 0, status bit 31 is set.
- R6: If a configuration write makes bit 30 go from 0 to 1, status bit 30 is set. If it makes bit 30 go from 1 to 0, status bit 30 is cleared.
- R7: The refresh timer stores the written value ANDed with 0x3FF80000. ECC configuration stores the value ANDed with 0x00F00000. ECC status stores the value ANDed with 0xFFF0F000. The idle timer stores (value AND 0xF8000000) OR 0x07C00000.
- R8: ecc_irq is high exactly while the stored ECC status is nonzero.
- R9: A bank register stores the written value ANDed with 0xFFDEE001. In a bank register, bit 0 is the valid bit, bits 31:23 give the base address (the remaining base bits are zero), and bits 19:17 give the size code. The bank size is 4 MiB shifted left by the code.
- R10: bank_hit[n] is high when all of these hold: configuration bit 31 is 1, bank n is valid, its size code is not 7, and sys_addr lies in [base, base + size). The range check uses a 33-bit sum, so a bank that ends at 2^32 covers the top address.
- R11: bank_sel is one-hot on the lowest-numbered bank that hits, and is zero when no bank hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 10 | Bus port number |
| wr_en | input | 1 | Write strobe for port_addr |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for port_addr (combinational) |
| sys_addr | input | 32 | System address to decode |
| bank_hit | output | 4 | Banks whose range contains sys_addr |
| bank_sel | output | 4 | One-hot select of the lowest hitting bank |
| ecc_irq | output | 1 | ECC interrupt |

## Verification
The bank decoder runs in every cycle, so a write to a bank register or to the configuration register can land in the same cycle as the decode of an address. The bench holds sys_addr steady while it rewrites a bank register or toggles the enable bit. It also moves sys_addr across bank edges that overlap and across the top of the address space. In every cycle a behavioural model predicts the hit vector from the register contents that are in place before the write takes effect, and the bench compares it with the design. Status-mirror transitions and the ECC interrupt are judged in the same way, cycle by cycle, against the model.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
    localparam int NBANK  = 4;
    localparam int DW     = 32;

    localparam logic [DW-1:0] OFF_ERRA  = 32'h00;
    localparam logic [DW-1:0] OFF_ERRB  = 32'h08;
    localparam logic [DW-1:0] OFF_EADDR = 32'h10;
    localparam logic [DW-1:0] OFF_CFG   = 32'h20;
    localparam logic [DW-1:0] OFF_STAT  = 32'h24;
    localparam logic [DW-1:0] OFF_RFSH  = 32'h30;
    localparam logic [DW-1:0] OFF_IDLE  = 32'h34;
    localparam logic [DW-1:0] OFF_BANK0 = 32'h40;
    localparam logic [DW-1:0] OFF_ECFG  = 32'h94;
    localparam logic [DW-1:0] OFF_ESTAT = 32'h98;

    localparam logic [DW-1:0] CFG_MASK   = 32'hFFE0_0000;
    localparam logic [DW-1:0] RFSH_MASK  = 32'h3FF8_0000;
    localparam logic [DW-1:0] IDLE_MASK  = 32'hF800_0000;
    localparam logic [DW-1:0] IDLE_FIXED = 32'h07C0_0000;
    localparam logic [DW-1:0] ECFG_MASK  = 32'h00F0_0000;
    localparam logic [DW-1:0] ESTAT_MASK = 32'hFFF0_F000;
    localparam logic [DW-1:0] BANK_MASK  = 32'hFFDE_E001;

    localparam logic [DW-1:0] CFG_RST  = 32'h0080_0000;
    localparam logic [DW-1:0] RFSH_RST = 32'h05F0_0000;
    localparam logic [DW-1:0] IDLE_RST = 32'h07C0_0000;

    localparam int EN_BIT = 31;
    localparam int SR_BIT = 30;

    typedef struct packed {
        logic [DW-1:0]            idx;
        logic [DW-1:0]            erra;
        logic [DW-1:0]            errb;
        logic [DW-1:0]            eaddr;
        logic [DW-1:0]            cfg;
        logic [DW-1:0]            stat;
        logic [DW-1:0]            rfsh;
        logic [DW-1:0]            idle;
        logic [DW-1:0]            ecfg;
        logic [DW-1:0]            estat;
        logic [NBANK-1:0][DW-1:0] bank;
    } regs_t;
endpackage

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
#(
    parameter int PORT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output regs_t             regs_q
);
    localparam logic [PORT_W-1:0] IDX_PORT  = PORT_W'(16);
    localparam logic [PORT_W-1:0] DATA_PORT = PORT_W'(17);

    regs_t state_d, state_q;
    logic [DW-1:0] cfg_new;

    always_comb begin
        state_d = state_q;
        cfg_new = wr_data & CFG_MASK;
        if (wr_en && port_addr == IDX_PORT) begin
            state_d.idx = wr_data;
        end
        if (wr_en && port_addr == DATA_PORT) begin
            case (state_q.idx)
                OFF_ERRA:  state_d.erra  = state_q.erra & ~wr_data;
                OFF_ERRB:  state_d.errb  = state_q.errb & ~wr_data;
                OFF_EADDR: state_d.eaddr = wr_data;
                OFF_CFG: begin
                    if (!state_q.cfg[EN_BIT] && cfg_new[EN_BIT])
                        state_d.stat[EN_BIT] = 1'b0;
                    else if (state_q.cfg[EN_BIT] && !cfg_new[EN_BIT])
                        state_d.stat[EN_BIT] = 1'b1;
                    if (state_q.cfg[SR_BIT] != cfg_new[SR_BIT])
                        state_d.stat[SR_BIT] = cfg_new[SR_BIT];
                    state_d.cfg = cfg_new;
                end
                OFF_RFSH:  state_d.rfsh  = wr_data & RFSH_MASK;
                OFF_IDLE:  state_d.idle  = (wr_data & IDLE_MASK) | IDLE_FIXED;
                OFF_ECFG:  state_d.ecfg  = wr_data & ECFG_MASK;
                OFF_ESTAT: state_d.estat = wr_data & ESTAT_MASK;
                default: ;
            endcase
            for (int b = 0; b < NBANK; b++) begin
                if (state_q.idx == OFF_BANK0 + DW'(4 * b))
                    state_d.bank[b] = wr_data & BANK_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.cfg  <= CFG_RST;
            state_q.rfsh <= RFSH_RST;
            state_q.idle <= IDLE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign regs_q = state_q;

    // R3
    stat_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_addr == DATA_PORT && state_q.idx == OFF_STAT &&
         state_q.cfg == (wr_data & CFG_MASK)) |=> $stable(state_q.stat));
    // R5
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.cfg[EN_BIT]) |-> state_q.stat[EN_BIT]);
    // R5
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.cfg[EN_BIT]) |-> !state_q.stat[EN_BIT]);
    // R6
    sr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.cfg[SR_BIT]) |-> state_q.stat[SR_BIT]);
    // R6
    sr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.cfg[SR_BIT]) |-> !state_q.stat[SR_BIT]);
endmodule

// File: rtl/sdram_cfg_rdmux.sv
module sdram_cfg_rdmux
    import sdram_cfg_pkg::*;
#(
    parameter int PORT_W = 10
) (
    input  regs_t             regs,
    input  logic [PORT_W-1:0] port_addr,
    output logic [DW-1:0]     rd_data
);
    localparam logic [PORT_W-1:0] IDX_PORT  = PORT_W'(16);
    localparam logic [PORT_W-1:0] DATA_PORT = PORT_W'(17);

    logic [DW-1:0] inner;

    always_comb begin
        case (regs.idx)
            OFF_ERRA:  inner = regs.erra;
            OFF_ERRB:  inner = regs.errb;
            OFF_EADDR: inner = regs.eaddr;
            OFF_CFG:   inner = regs.cfg;
            OFF_STAT:  inner = regs.stat;
            OFF_RFSH:  inner = regs.rfsh;
            OFF_IDLE:  inner = regs.idle;
            OFF_ECFG:  inner = regs.ecfg;
            OFF_ESTAT: inner = regs.estat;
            default:   inner = '1;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (regs.idx == OFF_BANK0 + DW'(4 * b))
                inner = regs.bank[b];
        end
        if (port_addr == IDX_PORT)
            rd_data = regs.idx;
        else if (port_addr == DATA_PORT)
            rd_data = inner;
        else
            rd_data = '0;
    end
endmodule

// File: rtl/sdram_bank_match.sv
module sdram_bank_match
    import sdram_cfg_pkg::*;
(
    input  logic          en,
    input  logic          valid,
    input  logic [8:0]    base_hi,
    input  logic [2:0]    size_code,
    input  logic [DW-1:0] addr,
    output logic          hit
);
    localparam logic [DW:0] UNIT = (DW+1)'(32'h0040_0000);

    logic [DW-1:0] base;
    logic [DW:0]   limit;

    always_comb begin
        base  = {base_hi, 23'd0};
        limit = {1'b0, base} + (UNIT << size_code);
        hit   = en && valid && (size_code != 3'd7) &&
                (addr >= base) && ({1'b0, addr} < limit);
    end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int PORT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic [DW-1:0]     sys_addr,
    output logic [NBANK-1:0]  bank_hit,
    output logic [NBANK-1:0]  bank_sel,
    output logic              ecc_irq
);
    regs_t regs;

    sdram_cfg_regfile #(.PORT_W(PORT_W)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_addr (port_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .regs_q    (regs)
    );

    sdram_cfg_rdmux #(.PORT_W(PORT_W)) u_rdmux (
        .regs      (regs),
        .port_addr (port_addr),
        .rd_data   (rd_data)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdram_bank_match u_match (
            .en        (regs.cfg[EN_BIT]),
            .valid     (regs.bank[b][0]),
            .base_hi   (regs.bank[b][31:23]),
            .size_code (regs.bank[b][19:17]),
            .addr      (sys_addr),
            .hit       (bank_hit[b])
        );
    end

    assign bank_sel = bank_hit & (~bank_hit + NBANK'(1));
    assign ecc_irq  = |regs.estat;

    // R10
    no_hit_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regs.cfg[EN_BIT] |-> bank_hit == '0);
    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));
    // R11
    sel_in_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel & ~bank_hit) == '0 && ((bank_hit != '0) == (bank_sel != '0)));
endmodule

// File: tb/sdram_cfg_regs_tb.sv
`timescale 1ns/1ps
module sdram_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  port_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] sys_addr = '0;
    logic [3:0]  bank_hit, bank_sel;
    logic        ecc_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sdram_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sys_addr(sys_addr),
        .bank_hit(bank_hit), .bank_sel(bank_sel), .ecc_irq(ecc_irq)
    );

    // behavioural model of the register contents
    logic [31:0] m_idx, m_erra, m_errb, m_eaddr, m_cfg, m_stat;
    logic [31:0] m_rfsh, m_idle, m_ecfg, m_estat;
    logic [31:0] m_bank [4];

    task automatic model_reset();
        m_idx = 0; m_erra = 0; m_errb = 0; m_eaddr = 0;
        m_cfg = 32'h0080_0000; m_stat = 0; m_rfsh = 32'h05F0_0000;
        m_idle = 32'h07C0_0000; m_ecfg = 0; m_estat = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] exp_inner();
        case (m_idx)
            32'h00: return m_erra;
            32'h08: return m_errb;
            32'h10: return m_eaddr;
            32'h20: return m_cfg;
            32'h24: return m_stat;
            32'h30: return m_rfsh;
            32'h34: return m_idle;
            32'h40: return m_bank[0];
            32'h44: return m_bank[1];
            32'h48: return m_bank[2];
            32'h4C: return m_bank[3];
            32'h94: return m_ecfg;
            32'h98: return m_estat;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int p);
        if (p == 16) return m_idx;
        if (p == 17) return exp_inner();
        return 32'h0;
    endfunction

    function automatic logic [3:0] exp_hit(input logic [31:0] a);
        logic [3:0] h = 0;
        for (int i = 0; i < 4; i++) begin
            longint base = longint'(m_bank[i] & 32'hFF80_0000);
            int     code = int'((m_bank[i] >> 17) & 7);
            longint size = longint'(4194304) << code;
            if (m_cfg[31] && m_bank[i][0] && code != 7 &&
                longint'(a) >= base && longint'(a) < base + size)
                h[i] = 1'b1;
        end
        return h;
    endfunction

    function automatic logic [3:0] exp_sel(input logic [3:0] h);
        for (int i = 0; i < 4; i++) if (h[i]) return 4'(1 << i);
        return 4'h0;
    endfunction

    task automatic model_write(input int p, input logic [31:0] v);
        logic [31:0] c;
        if (p == 16) begin
            m_idx = v;
        end else if (p == 17) begin
            case (m_idx)
                32'h00: m_erra = m_erra & ~v;
                32'h08: m_errb = m_errb & ~v;
                32'h10: m_eaddr = v;
                32'h20: begin
                    c = v & 32'hFFE0_0000;
                    if (m_cfg[31] == 1'b0 && c[31] == 1'b1) m_stat[31] = 1'b0;
                    if (m_cfg[31] == 1'b1 && c[31] == 1'b0) m_stat[31] = 1'b1;
                    if (m_cfg[30] == 1'b0 && c[30] == 1'b1) m_stat[30] = 1'b1;
                    if (m_cfg[30] == 1'b1 && c[30] == 1'b0) m_stat[30] = 1'b0;
                    m_cfg = c;
                end
                32'h30: m_rfsh = v & 32'h3FF8_0000;
                32'h34: m_idle = (v & 32'hF800_0000) | 32'h07C0_0000;
                32'h40: m_bank[0] = v & 32'hFFDE_E001;
                32'h44: m_bank[1] = v & 32'hFFDE_E001;
                32'h48: m_bank[2] = v & 32'hFFDE_E001;
                32'h4C: m_bank[3] = v & 32'hFFDE_E001;
                32'h94: m_ecfg = v & 32'h00F0_0000;
                32'h98: m_estat = v & 32'hFFF0_F000;
                default: ;
            endcase
        end
    endtask

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one cycle: drive inputs, compare outputs against the model, commit
    task automatic step(input string req, input bit w, input int p,
                        input logic [31:0] v, input logic [31:0] a);
        logic [3:0] h;
        wr_en = w; port_addr = 10'(p); wr_data = v; sys_addr = a;
        #1;
        h = exp_hit(a);
        cmp(req, rd_data, exp_rd(p));
        cmp("R10", 32'(bank_hit), 32'(h));
        cmp("R11", 32'(bank_sel), 32'(exp_sel(h)));
        cmp("R8", 32'(ecc_irq), 32'(m_estat != 0));
        @(posedge clk);
        if (w) model_write(p, v);
        @(negedge clk);
    endtask

    task automatic wreg(input string req, input logic [31:0] off, input logic [31:0] v);
        step(req, 1, 16, off, sys_addr);
        step(req, 1, 17, v, sys_addr);
    endtask

    task automatic rreg(input string req, input logic [31:0] off);
        step(req, 1, 16, off, sys_addr);
        step(req, 0, 17, 0, sys_addr);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset values
        step("R2", 0, 16, 0, 0);
        foreach (m_bank[i]) rreg("R2", 32'h40 + 4 * i);
        rreg("R2", 32'h34); rreg("R2", 32'h30); rreg("R2", 32'h20);
        rreg("R2", 32'h24); rreg("R2", 32'h98); rreg("R2", 32'h10);

        // R1 port decode
        step("R1", 1, 16, 32'h0000_0020, 0);
        step("R1", 0, 16, 0, 0);
        step("R1", 0, 17, 0, 0);
        step("R1", 0, 5, 0, 0);
        step("R1", 1, 5, 32'hFFFF_FFFF, 0);
        step("R1", 1, 18, 32'hFFFF_FFFF, 0);
        step("R1", 0, 17, 0, 0);
        step("R1", 0, 16, 0, 0);

        // R3 timing, unmapped, status writes
        rreg("R3", 32'h80);
        wreg("R3", 32'h80, 32'h1234_5678);
        rreg("R3", 32'h80);
        rreg("R3", 32'h84);
        rreg("R3", 32'h0000_1020);
        wreg("R3", 32'h24, 32'hFFFF_FFFF);
        rreg("R3", 32'h24);

        // R4 error registers
        wreg("R4", 32'h00, 32'hFFFF_FFFF); rreg("R4", 32'h00);
        wreg("R4", 32'h08, 32'h0F0F_0F0F); rreg("R4", 32'h08);
        wreg("R4", 32'h10, 32'hDEAD_BEEF); rreg("R4", 32'h10);

        // R5 / R6 configuration and status mirror
        wreg("R5", 32'h20, 32'hFFFF_FFFF); rreg("R5", 32'h20); rreg("R6", 32'h24);
        wreg("R6", 32'h20, 32'h8000_0000); rreg("R6", 32'h24);
        wreg("R5", 32'h20, 32'h4000_0000); rreg("R5", 32'h24);
        wreg("R5", 32'h20, 32'hC000_0000); rreg("R5", 32'h24);
        wreg("R6", 32'h20, 32'h0000_0000); rreg("R6", 32'h24);

        // R7 masks
        wreg("R7", 32'h30, 32'hFFFF_FFFF); rreg("R7", 32'h30);
        wreg("R7", 32'h34, 32'h0000_0000); rreg("R7", 32'h34);
        wreg("R7", 32'h34, 32'hFFFF_FFFF); rreg("R7", 32'h34);
        wreg("R7", 32'h94, 32'hFFFF_FFFF); rreg("R7", 32'h94);

        // R8 ECC interrupt
        wreg("R8", 32'h98, 32'h0000_F000); rreg("R8", 32'h98);
        wreg("R8", 32'h98, 32'h0000_0000); rreg("R8", 32'h98);
        wreg("R8", 32'h98, 32'h000F_0FFF); rreg("R8", 32'h98);
        wreg("R8", 32'h98, 32'h8000_0000); rreg("R8", 32'h98);
        wreg("R8", 32'h98, 32'h0);

        // R9 bank masks
        wreg("R9", 32'h40, 32'hFFFF_FFFF); rreg("R9", 32'h40);

        // R10 / R11 decode with overlapping banks
        wreg("R9", 32'h40, 32'h0004_0001);
        wreg("R9", 32'h44, 32'h0080_0001);
        wreg("R9", 32'h48, 32'h100C_0001);
        wreg("R9", 32'h4C, 32'hFF8C_0001);
        step("R10", 0, 0, 0, 32'h0000_0000);
        wreg("R10", 32'h20, 32'h8000_0000);
        begin
            logic [31:0] pts [14] = '{32'h0, 32'h007F_FFFF, 32'h0080_0000,
                32'h00BF_FFFF, 32'h00C0_0000, 32'h00FF_FFFF, 32'h0100_0000,
                32'h0FFF_FFFF, 32'h1000_0000, 32'h1FFF_FFFF, 32'h2000_0000,
                32'hFF7F_FFFF, 32'hFF80_0000, 32'hFFFF_FFFF};
            foreach (pts[i]) step("R11", 0, 0, 0, pts[i]);
        end
        // bank rewrite while the address is held in range
        step("R10", 1, 16, 32'h44, 32'h0090_0000);
        step("R10", 1, 17, 32'h0080_0000, 32'h0090_0000);
        step("R10", 0, 0, 0, 32'h0090_0000);
        // size code 7 is never a hit
        wreg("R10", 32'h4C, 32'hFF8E_0001);
        step("R10", 0, 0, 0, 32'hFFFF_FFFF);
        // disable in the same cycle as a hit
        step("R10", 1, 16, 32'h20, 32'h0000_1000);
        step("R10", 1, 17, 32'h0, 32'h0000_1000);
        step("R10", 0, 0, 0, 32'h0000_1000);
        rreg("R5", 32'h24);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule